// File: doc/BRIEF.md
# Pocket Calculator Control Sequencer

This block is the control core of a small integer calculator with three decimal digits. A keypad scanner gives it a 4-bit key code and a strobe that stays high while a key is held. Digit keys build an operand in decimal. An operator key does not act on itself. It applies the operator stored by the previous press to the running result, then stores itself for the next press. The value to show is kept in a binary display register. A later stage converts that register to decimal digits.

Addition, subtraction and multiplication finish in a single clock. Division goes to an external iterative divider. The sequencer loads the divider operands, pulses a start strobe and waits for the divider's done strobe. The sequencer acts on each key press once, then ignores the keypad until the strobe drops.

Top module: `calc_seq`

## Requirements
- R1: After reset, `disp_value` is 0 and `div_start` is low. The running result and the operand are both zero, and the stored operator is add.
- R2: A digit key (code 0x0 to 0x9) sets the operand to operand*10 + digit. `disp_value` then shows the new operand.
- R3: A digit key is ignored when the operand is 100 or more, so the operand never exceeds 999.
- R4: Operator codes are 0xA add, 0xB subtract, 0xD multiply, 0xE divide and 0xF equals. An operator key applies the stored operator to (result, operand), stores the pressed operator and clears the operand to 0. `disp_value` then shows the new result.
- R5: The first operator or equals after reset or clear loads the result with the entered operand.
- R6: Add, subtract and multiply are taken modulo 2^DATA_W.
- R7: For a stored divide, `div_num` is loaded with the result and `div_den` with the operand. `div_start` is high for exactly one cycle. The operands are held while the sequencer waits. On `div_done` the result becomes `div_quot`.
- R8: Equals stores a hold operator. The next operator press leaves the result unchanged and ignores the operand.
- R9: Key 0xC clears the result, the operand and the stored operator, and sets `disp_value` to 0.
- R10: A key is acted on once per press. No new key is accepted until `key_valid` has gone low. Keys that arrive during a division wait have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_code | input | 4 | Decoded key code |
| key_valid | input | 1 | High while a key is pressed |
| div_start | output | 1 | One-cycle start strobe to the divider |
| div_num | output | DATA_W | Divider numerator |
| div_den | output | DATA_W | Divider denominator |
| div_quot | input | DATA_W | Divider quotient |
| div_done | input | 1 | Divider completion strobe |
| disp_value | output | DATA_W | Binary value to display |

## Verification
The hardest case to reach is a key that changes while a division is still in flight. The strobe stays high, but a different code appears during the wait. The stimulus holds `key_valid` across the whole divider latency and switches the code to a digit partway through. It then checks two things: the quotient is shown, and the next digit starts a fresh operand. Keys held for several cycles, the digit cap and results that wrap are reached through one long key sequence. That sequence also records the operands that the divider saw.

// File: rtl/calc_pkg.sv
package calc_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_DIV  = 3'd3,
    OP_HOLD = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    KEY_DIGIT = 2'd0,
    KEY_OPER  = 2'd1,
    KEY_CLEAR = 2'd2
  } key_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DIGIT    = 3'd1,
    ST_CALC     = 3'd2,
    ST_DIV_WAIT = 3'd3,
    ST_SHOW     = 3'd4,
    ST_RELEASE  = 3'd5
  } state_e;

  // key codes whose meaning the sequencer decodes
  localparam logic [3:0] CODE_ADD   = 4'hA;
  localparam logic [3:0] CODE_SUB   = 4'hB;
  localparam logic [3:0] CODE_CLEAR = 4'hC;
  localparam logic [3:0] CODE_MUL   = 4'hD;
  localparam logic [3:0] CODE_DIV   = 4'hE;
  localparam logic [3:0] CODE_EQ    = 4'hF;

  function automatic int pow10(input int n);
    int v;
    v = 1;
    for (int i = 0; i < n; i++) v = v * 10;
    return v;
  endfunction

endpackage

// File: rtl/calc_rst_sync.sv
module calc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/calc_key_decode.sv
module calc_key_decode
  import calc_pkg::*;
(
  input  logic [3:0] code,
  output key_kind_e  kind,
  output op_e        op
);
  always_comb begin
    kind = KEY_OPER;
    op   = OP_HOLD;
    if (code <= 4'd9) begin
      kind = KEY_DIGIT;
    end else begin
      unique case (code)
        CODE_ADD:   op = OP_ADD;
        CODE_SUB:   op = OP_SUB;
        CODE_MUL:   op = OP_MUL;
        CODE_DIV:   op = OP_DIV;
        CODE_CLEAR: kind = KEY_CLEAR;
        default:    op = OP_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/calc_operand.sv
module calc_operand
  import calc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIGITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_en,
  input  logic [3:0]        digit,
  output logic [DATA_W-1:0] arg_q,
  output logic [DATA_W-1:0] arg_acc
);
  localparam int ACC_LIMIT = pow10(DIGITS - 1);

  logic room;

  always_comb begin
    room    = (arg_q < DATA_W'(ACC_LIMIT));
    arg_acc = room ? (arg_q * DATA_W'(10) + {{(DATA_W-4){1'b0}}, digit}) : arg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arg_q <= '0;
    else if (clr)     arg_q <= '0;
    else if (load_en) arg_q <= arg_acc;
  end
endmodule

// File: rtl/calc_alu.sv
module calc_alu
  import calc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  logic [2*DATA_W-1:0] prod;

  always_comb begin
    prod = a * b;
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = prod[DATA_W-1:0];
      default: y = a;
    endcase
  end
endmodule

// File: rtl/calc_seq.sv
module calc_seq
  import calc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIGITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        key_code,
  input  logic              key_valid,
  output logic              div_start,
  output logic [DATA_W-1:0] div_num,
  output logic [DATA_W-1:0] div_den,
  input  logic [DATA_W-1:0] div_quot,
  input  logic              div_done,
  output logic [DATA_W-1:0] disp_value
);
  logic              rst_sync_n;
  state_e            state_q, state_d;
  key_kind_e         dec_kind;
  op_e               dec_op;
  logic [3:0]        key_q;
  op_e               op_new_q;
  op_e               op_q;
  logic [DATA_W-1:0] result_q;
  logic [DATA_W-1:0] arg_q;
  logic [DATA_W-1:0] arg_acc;
  logic [DATA_W-1:0] alu_y;
  logic              key_take;
  logic              clr_all;
  logic              calc_fast;
  logic              calc_div;
  logic              div_finish;
  logic              calc_done;

  calc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  calc_key_decode u_dec (
    .code (key_code),
    .kind (dec_kind),
    .op   (dec_op)
  );

  calc_operand #(.DATA_W(DATA_W), .DIGITS(DIGITS)) u_arg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (clr_all | calc_done),
    .load_en (state_q == ST_DIGIT),
    .digit   (key_q),
    .arg_q   (arg_q),
    .arg_acc (arg_acc)
  );

  calc_alu #(.DATA_W(DATA_W)) u_alu (
    .op (op_q),
    .a  (result_q),
    .b  (arg_q),
    .y  (alu_y)
  );

  // control strobes
  always_comb begin
    key_take   = (state_q == ST_IDLE) && key_valid;
    clr_all    = key_take && (dec_kind == KEY_CLEAR);
    calc_fast  = (state_q == ST_CALC) && (op_q != OP_DIV);
    calc_div   = (state_q == ST_CALC) && (op_q == OP_DIV);
    div_finish = (state_q == ST_DIV_WAIT) && div_done;
    calc_done  = calc_fast || div_finish;
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (key_valid) begin
          if (dec_kind == KEY_DIGIT)      state_d = ST_DIGIT;
          else if (dec_kind == KEY_CLEAR) state_d = ST_RELEASE;
          else                            state_d = ST_CALC;
        end
      end
      ST_DIGIT:    state_d = ST_RELEASE;
      ST_CALC:     state_d = (op_q == OP_DIV) ? ST_DIV_WAIT : ST_SHOW;
      ST_DIV_WAIT: if (div_done) state_d = ST_SHOW;
      ST_SHOW:     state_d = ST_RELEASE;
      ST_RELEASE:  if (!key_valid) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  // latched key
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      key_q    <= '0;
      op_new_q <= OP_ADD;
    end else if (key_take) begin
      key_q    <= key_code;
      op_new_q <= dec_op;
    end
  end

  // stored operator
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    op_q <= OP_ADD;
    else if (clr_all)   op_q <= OP_ADD;
    else if (calc_done) op_q <= op_new_q;
  end

  // running result
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     result_q <= '0;
    else if (clr_all)    result_q <= '0;
    else if (calc_fast)  result_q <= alu_y;
    else if (div_finish) result_q <= div_quot;
  end

  // divider interface
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      div_start <= 1'b0;
      div_num   <= '0;
      div_den   <= '0;
    end else begin
      div_start <= calc_div;
      if (calc_div) begin
        div_num <= result_q;
        div_den <= arg_q;
      end
    end
  end

  // display register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                disp_value <= '0;
    else if (clr_all)               disp_value <= '0;
    else if (state_q == ST_DIGIT)   disp_value <= arg_acc;
    else if (state_q == ST_SHOW)    disp_value <= result_q;
  end
endmodule

// File: rtl/calc_seq_chk.sv
module calc_seq_chk
  import calc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIGITS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_valid,
  input state_e            state,
  input logic [DATA_W-1:0] arg,
  input logic              div_start,
  input logic              div_done,
  input logic [DATA_W-1:0] div_num,
  input logic [DATA_W-1:0] div_den,
  input logic [DATA_W-1:0] disp_value
);
  localparam int ARG_MAX = pow10(DIGITS);

  // R7
  div_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> !div_start);

  // R7
  div_operands_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DIV_WAIT && $past(state) == ST_DIV_WAIT) |-> ($stable(div_num) && $stable(div_den)));

  // R7
  div_wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DIV_WAIT && !div_done) |=> (state == ST_DIV_WAIT));

  // R3
  arg_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arg < DATA_W'(ARG_MAX));

  // R10
  release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RELEASE && key_valid) |=> (state == ST_RELEASE));

  // R2
  disp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CALC || state == ST_DIV_WAIT || state == ST_RELEASE) |=> $stable(disp_value));
endmodule

bind calc_seq calc_seq_chk #(.DATA_W(DATA_W), .DIGITS(DIGITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .key_valid  (key_valid),
  .state      (state_q),
  .arg        (arg_q),
  .div_start  (div_start),
  .div_done   (div_done),
  .div_num    (div_num),
  .div_den    (div_den),
  .disp_value (disp_value)
);

// File: tb/test_calc_seq.sv
module test_calc_seq;
  localparam int DATA_W = 16;
  localparam int NVEC   = 36;
  localparam int DIV_LAT = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [3:0]        key_code;
  logic              key_valid;
  logic              div_start;
  logic [DATA_W-1:0] div_num, div_den, div_quot;
  logic              div_done;
  logic [DATA_W-1:0] disp_value;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int start_cnt = 0;
  logic [DATA_W-1:0] seen_num, seen_den;
  int lat_cnt = 0;

  always #2.5 clk = ~clk;

  calc_seq #(.DATA_W(DATA_W), .DIGITS(3)) i_calc_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_code   (key_code),
    .key_valid  (key_valid),
    .div_start  (div_start),
    .div_num    (div_num),
    .div_den    (div_den),
    .div_quot   (div_quot),
    .div_done   (div_done),
    .disp_value (disp_value)
  );

  // behavioural divider with fixed latency
  always @(posedge clk) begin
    div_done <= 1'b0;
    if (div_start) begin
      start_cnt <= start_cnt + 1;
      seen_num  <= div_num;
      seen_den  <= div_den;
      lat_cnt   <= DIV_LAT;
    end else if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        div_done <= 1'b1;
        div_quot <= (div_den == 0) ? '1 : div_num / div_den;
      end
    end
  end

  // {key, expected display}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'h1, 16'd1},     // R2
    {4'h2, 16'd12},    // R2
    {4'h3, 16'd123},   // R2
    {4'h4, 16'd123},   // R3 cap
    {4'hA, 16'd123},   // R5 first operator loads result
    {4'h7, 16'd7},     // R4 operand cleared
    {4'hB, 16'd130},   // R4 stored add applied
    {4'h3, 16'd3},
    {4'h0, 16'd30},    // R2 zero digit
    {4'hD, 16'd100},   // R6 subtract
    {4'h4, 16'd4},
    {4'hE, 16'd400},   // R6 multiply
    {4'h7, 16'd7},
    {4'hF, 16'd57},    // R7 division
    {4'hA, 16'd57},    // R8 hold after equals
    {4'h5, 16'd5},
    {4'hF, 16'd62},    // R4
    {4'hC, 16'd0},     // R9
    {4'h5, 16'd5},
    {4'hB, 16'd5},     // R5 after clear
    {4'h9, 16'd9},
    {4'hF, 16'd65532}, // R6 wrap below zero
    {4'hC, 16'd0},     // R9
    {4'h9, 16'd9},
    {4'h9, 16'd99},
    {4'h9, 16'd999},
    {4'hD, 16'd999},
    {4'h9, 16'd9},
    {4'h9, 16'd99},
    {4'h9, 16'd999},
    {4'hF, 16'd14961}, // R6 product wraps
    {4'hC, 16'd0},
    {4'h0, 16'd0},
    {4'h0, 16'd0},
    {4'h7, 16'd7},
    {4'hF, 16'd7}      // R5 equals first
  };

  task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic press(input logic [3:0] code, input int hold);
    @(negedge clk);
    key_code  = code;
    key_valid = 1'b1;
    repeat (hold) @(negedge clk);
    key_valid = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int starts_before;
    rst_n     = 1'b0;
    key_code  = 4'h0;
    key_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(disp_value, 16'd0, "R1 display");
    check({15'd0, div_start}, 16'd0, "R1 div_start");

    // main table, keys held for several cycles (R10 acts once)
    for (int i = 0; i < NVEC; i++) begin
      press(VEC[i][19:16], 4);
      check(disp_value, VEC[i][15:0], $sformatf("R2/R4 vector %0d", i));
    end

    // R7 operands and single start per division
    press(4'hC, 2);
    press(4'h8, 2);
    press(4'h4, 2);
    press(4'hE, 2);
    press(4'h2, 2);
    starts_before = start_cnt;
    // R10: key held through the division, code changes mid-wait
    @(negedge clk);
    key_code  = 4'hF;
    key_valid = 1'b1;
    repeat (3) @(negedge clk);
    key_code = 4'h5;
    repeat (20) @(negedge clk);
    key_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(seen_num, 16'd84, "R7 numerator");
    check(seen_den, 16'd2, "R7 denominator");
    check(16'(start_cnt - starts_before), 16'd1, "R7 one start");
    check(disp_value, 16'd42, "R10 quotient kept");
    press(4'h3, 2);
    check(disp_value, 16'd3, "R10 no stray digit");

    // R1 reset mid-entry
    press(4'h6, 2);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(disp_value, 16'd0, "R1 display after reset");
    press(4'h2, 2);
    press(4'hF, 2);
    check(disp_value, 16'd2, "R1 R5 result zero after reset");

    summary();
  end
endmodule